// File: doc/BRIEF.md
# Flash Command Sequencer

This block is the command front end of a byte-wide flash array that is divided into sectors. On each clock edge where `wr_en` is high it examines a 17-bit address and an 8-bit data value. It steps through multi-write unlock sequences that ask for a return to read mode, a single-byte program, a whole-array erase, or an erase of chosen sectors. Once a program or erase has been requested, the block runs it for a fixed number of clock cycles, which stands in for the real cell timing. While that runs, reads return a status byte. At all other times reads return the contents of the array.

The array is a small register file inside the block. Each sector holds `1<<LOC_W` bytes. A byte is selected by address bits 16:14, which give the sector, and by address bits `LOC_W-1:0`, which give the location. Every other address bit aliases. A test input can force a time-limit fault while an operation is running, so that the fault status encoding can be exercised.

Top module: `flash_cmd_seq`

## Requirements
- R1: During reset and afterwards, until the first read, `rdata` is 00h. After reset the block is in read mode and every array byte reads FFh. `rdata` changes only at the clock edge that samples `rd_en`.
- R2: A command starts only with AAh written where address bits 14:0 equal 5555h, followed by 55h written where bits 14:0 equal 2AAAh. Bits 16:15 are ignored in both. Any other write in an unlock step sends the decoder back to idle.
- R3: If the third write is F0h at 5555h, the block returns to read mode, and the next write does not change the array.
- R4: If the third write is A0h at 5555h, the fourth write gives the target address and data. The program takes effect PROG_CYCLES cycles after that write.
- R5: The status byte has these fields: bit 7 is poll, bit 6 is toggle, bit 5 is time limit, bit 4 is fault kind, bit 3 is erase started, and bits 2:0 are 0. While a program is running, bit 7 is the inverse of the programmed bit 7, bits 5:3 are 0, and every write is ignored.
- R6: Bit 6 reads 0 on the first status read after read mode. It then inverts on each status read.
- R7: The sequence 80h, then AAh at 5555h, 55h at 2AAAh, and 10h at 5555h starts a chip erase. Until the erase completes, status reads bit 7 = 0 and bit 3 = 1. Every byte then reads FFh.
- R8: Ending the same six-write sequence with 30h at any address opens a window of WINDOW_CYCLES cycles, during which bit 3 reads 0. Each further 30h adds the addressed sector to the erase set and restarts the window. When the window runs out, the erase starts and lasts ERASE_CYCLES cycles. Only the sectors in the set become FFh.
- R9: Any write in the window other than 30h cancels the sector erase, empties the erase set and returns the block to read mode.
- R10: Writes received during an erase are ignored.
- R11: If `fault_inject` is high during a program or erase, the operation stops with the array unchanged. Status then reads bit 5 = 1, and bit 4 = 0 for a program or 1 for an erase. Bits 7 and 3 keep their per-kind meaning. The fault holds until a write of F0h.
- R12: When a program or erase ends, the block returns to read mode by itself.
- R13: A program only clears bits. The stored byte becomes the old byte ANDed with the written data.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write strobe, one write per cycle |
| rd_en | input | 1 | Read strobe, result in `rdata` after the edge |
| addr | input | 17 | Byte address |
| wdata | input | 8 | Write data or command byte |
| fault_inject | input | 1 | Test input that forces a time-limit fault |
| rdata | output | 8 | Array byte or status byte |

## Verification
A wrong decoder state shows up at the ports as one of two symptoms. Either a read returns status where array data was expected, or the reverse. The symptom appears on the very next read, because every status bit comes straight from the decoder state. A sequence step that is accepted or dropped in error is caught later. A program or erase then lands where none was expected, or is missing where one was expected, and a data read after the nominal duration shows it. The window-restart test places a status read in the cycle where an erase would already show bit 3 if the restart had been lost.

// File: rtl/flash_cmd_pkg.sv
package flash_cmd_pkg;

  typedef enum logic [3:0] {
    S_IDLE, S_UNL1, S_UNL2, S_PGM_SETUP,
    S_ERS_SETUP, S_ERS_UNL1, S_ERS_UNL2,
    S_WINDOW, S_PGM_BUSY, S_ERS_BUSY, S_FAULT
  } seq_state_e;

  localparam logic [7:0]  CMD_KEY_A   = 8'hAA;
  localparam logic [7:0]  CMD_KEY_B   = 8'h55;
  localparam logic [7:0]  CMD_RESET   = 8'hF0;
  localparam logic [7:0]  CMD_PROGRAM = 8'hA0;
  localparam logic [7:0]  CMD_ERASE   = 8'h80;
  localparam logic [7:0]  CMD_CHIP    = 8'h10;
  localparam logic [7:0]  CMD_SECTOR  = 8'h30;
  localparam logic [14:0] KEY_ADDR_A  = 15'h5555;
  localparam logic [14:0] KEY_ADDR_B  = 15'h2AAA;

  // address/data pair matches one unlock or command step
  function automatic logic key_hit(input logic [14:0] low_addr,
                                   input logic [14:0] want_addr,
                                   input logic [7:0]  data,
                                   input logic [7:0]  want_data);
    return (low_addr == want_addr) && (data == want_data);
  endfunction

  // status byte layout: poll, toggle, limit, kind, erase started
  function automatic logic [7:0] status_byte(input logic poll,
                                             input logic tog,
                                             input logic limit,
                                             input logic kind,
                                             input logic started);
    return {poll, tog, limit, kind, started, 3'b000};
  endfunction

  // programming can only pull bits to zero
  function automatic logic [7:0] program_merge(input logic [7:0] old_b,
                                               input logic [7:0] new_b);
    return old_b & new_b;
  endfunction

  function automatic int max3(input int a, input int b, input int c);
    int m;
    m = (a > b) ? a : b;
    return (m > c) ? m : c;
  endfunction

endpackage

// File: rtl/fcs_decoder.sv
module fcs_decoder
  import flash_cmd_pkg::*;
#(
  parameter int ADDR_W        = 17,
  parameter int SECT_W        = 3,
  parameter int LOC_W         = 2,
  parameter int PROG_CYCLES   = 8,
  parameter int ERASE_CYCLES  = 16,
  parameter int WINDOW_CYCLES = 6
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  wr_en,
  input  logic [ADDR_W-1:0]     addr,
  input  logic [7:0]            wdata,
  input  logic                  fault_inject,
  output logic                  busy_prog,
  output logic                  busy_erase,
  output logic                  in_window,
  output logic                  in_fault,
  output logic                  fault_kind,
  output logic                  prog_fire,
  output logic                  erase_fire,
  output logic [(1<<SECT_W)-1:0] erase_mask,
  output logic [SECT_W-1:0]     tgt_sect,
  output logic [LOC_W-1:0]      tgt_loc,
  output logic [7:0]            tgt_data
);
  localparam int NSECT = 1 << SECT_W;
  localparam int MAXC  = max3(PROG_CYCLES, ERASE_CYCLES, WINDOW_CYCLES);
  localparam int CNT_W = $clog2(MAXC + 1);

  seq_state_e          st, st_n;
  logic [CNT_W-1:0]    cnt, cnt_n;
  logic [NSECT-1:0]    mask_n;
  logic [SECT_W-1:0]   sect_n;
  logic [LOC_W-1:0]    loc_n;
  logic [7:0]          data_n;
  logic                kind_n;

  logic [14:0]         low_addr;
  logic [SECT_W-1:0]   wr_sect;
  logic [NSECT-1:0]    wr_sect_oh;
  logic                cnt_zero;

  assign low_addr   = addr[14:0];
  assign wr_sect    = addr[ADDR_W-1 -: SECT_W];
  assign wr_sect_oh = NSECT'(1) << wr_sect;
  assign cnt_zero   = (cnt == '0);

  always_comb begin
    st_n       = st;
    cnt_n      = cnt;
    mask_n     = erase_mask;
    sect_n     = tgt_sect;
    loc_n      = tgt_loc;
    data_n     = tgt_data;
    kind_n     = fault_kind;
    prog_fire  = 1'b0;
    erase_fire = 1'b0;
    unique case (st)
      S_IDLE: begin
        if (wr_en && key_hit(low_addr, KEY_ADDR_A, wdata, CMD_KEY_A)) st_n = S_UNL1;
      end
      S_UNL1: begin
        if (wr_en) st_n = key_hit(low_addr, KEY_ADDR_B, wdata, CMD_KEY_B) ? S_UNL2 : S_IDLE;
      end
      S_UNL2: begin
        if (wr_en) begin
          st_n = S_IDLE;
          if (low_addr == KEY_ADDR_A) begin
            if (wdata == CMD_PROGRAM)    st_n = S_PGM_SETUP;
            else if (wdata == CMD_ERASE) st_n = S_ERS_SETUP;
          end
        end
      end
      S_PGM_SETUP: begin
        if (wr_en) begin
          sect_n = wr_sect;
          loc_n  = addr[LOC_W-1:0];
          data_n = wdata;
          cnt_n  = CNT_W'(PROG_CYCLES - 1);
          st_n   = S_PGM_BUSY;
        end
      end
      S_ERS_SETUP: begin
        if (wr_en) st_n = key_hit(low_addr, KEY_ADDR_A, wdata, CMD_KEY_A) ? S_ERS_UNL1 : S_IDLE;
      end
      S_ERS_UNL1: begin
        if (wr_en) st_n = key_hit(low_addr, KEY_ADDR_B, wdata, CMD_KEY_B) ? S_ERS_UNL2 : S_IDLE;
      end
      S_ERS_UNL2: begin
        if (wr_en) begin
          if (key_hit(low_addr, KEY_ADDR_A, wdata, CMD_CHIP)) begin
            mask_n = '1;
            cnt_n  = CNT_W'(ERASE_CYCLES - 1);
            st_n   = S_ERS_BUSY;
          end else if (wdata == CMD_SECTOR) begin
            mask_n = wr_sect_oh;
            cnt_n  = CNT_W'(WINDOW_CYCLES - 1);
            st_n   = S_WINDOW;
          end else begin
            st_n = S_IDLE;
          end
        end
      end
      S_WINDOW: begin
        if (wr_en) begin
          if (wdata == CMD_SECTOR) begin
            mask_n = erase_mask | wr_sect_oh;
            cnt_n  = CNT_W'(WINDOW_CYCLES - 1);
          end else begin
            mask_n = '0;
            st_n   = S_IDLE;
          end
        end else if (cnt_zero) begin
          cnt_n = CNT_W'(ERASE_CYCLES - 1);
          st_n  = S_ERS_BUSY;
        end else begin
          cnt_n = cnt - 1'b1;
        end
      end
      S_PGM_BUSY: begin
        if (fault_inject) begin
          kind_n = 1'b0;
          st_n   = S_FAULT;
        end else if (cnt_zero) begin
          prog_fire = 1'b1;
          st_n      = S_IDLE;
        end else begin
          cnt_n = cnt - 1'b1;
        end
      end
      S_ERS_BUSY: begin
        if (fault_inject) begin
          kind_n = 1'b1;
          mask_n = '0;
          st_n   = S_FAULT;
        end else if (cnt_zero) begin
          erase_fire = 1'b1;
          mask_n     = '0;
          st_n       = S_IDLE;
        end else begin
          cnt_n = cnt - 1'b1;
        end
      end
      S_FAULT: begin
        if (wr_en && wdata == CMD_RESET) st_n = S_IDLE;
      end
      default: st_n = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st         <= S_IDLE;
      cnt        <= '0;
      erase_mask <= '0;
      tgt_sect   <= '0;
      tgt_loc    <= '0;
      tgt_data   <= '0;
      fault_kind <= 1'b0;
    end else begin
      st         <= st_n;
      cnt        <= cnt_n;
      erase_mask <= mask_n;
      tgt_sect   <= sect_n;
      tgt_loc    <= loc_n;
      tgt_data   <= data_n;
      fault_kind <= kind_n;
    end
  end

  assign busy_prog  = (st == S_PGM_BUSY);
  assign busy_erase = (st == S_ERS_BUSY);
  assign in_window  = (st == S_WINDOW);
  assign in_fault   = (st == S_FAULT);

endmodule

// File: rtl/fcs_array.sv
module fcs_array
  import flash_cmd_pkg::*;
#(
  parameter int SECT_W = 3,
  parameter int LOC_W  = 2
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   prog_fire,
  input  logic [SECT_W-1:0]      prog_sect,
  input  logic [LOC_W-1:0]       prog_loc,
  input  logic [7:0]             prog_data,
  input  logic                   erase_fire,
  input  logic [(1<<SECT_W)-1:0] erase_mask,
  input  logic [SECT_W-1:0]      rd_sect,
  input  logic [LOC_W-1:0]       rd_loc,
  output logic [7:0]             rd_byte
);
  localparam int NSECT = 1 << SECT_W;
  localparam int NLOC  = 1 << LOC_W;

  logic [7:0] sect_rd [NSECT];

  for (genvar s = 0; s < NSECT; s++) begin : g_sect
    logic [7:0] cells [NLOC];
    logic       hit_prog;

    assign hit_prog   = prog_fire && (prog_sect == SECT_W'(s));
    assign sect_rd[s] = cells[rd_loc];

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        for (int i = 0; i < NLOC; i++) cells[i] <= 8'hFF;
      end else if (erase_fire && erase_mask[s]) begin
        for (int i = 0; i < NLOC; i++) cells[i] <= 8'hFF;
      end else if (hit_prog) begin
        cells[prog_loc] <= program_merge(cells[prog_loc], prog_data);
      end
    end
  end

  assign rd_byte = sect_rd[rd_sect];

endmodule

// File: rtl/fcs_readout.sv
module fcs_readout
  import flash_cmd_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       rd_en,
  input  logic       status_mode,
  input  logic       poll_bit,
  input  logic       limit_bit,
  input  logic       kind_bit,
  input  logic       started_bit,
  input  logic [7:0] array_byte,
  output logic [7:0] rdata
);
  logic tog;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdata <= 8'h00;
      tog   <= 1'b0;
    end else begin
      if (!status_mode) tog <= 1'b0;
      if (rd_en) begin
        if (status_mode) begin
          rdata <= status_byte(poll_bit, tog, limit_bit, kind_bit, started_bit);
          tog   <= ~tog;
        end else begin
          rdata <= array_byte;
        end
      end
    end
  end

endmodule

// File: rtl/flash_cmd_seq.sv
module flash_cmd_seq
  import flash_cmd_pkg::*;
#(
  parameter int ADDR_W        = 17,
  parameter int SECT_W        = 3,
  parameter int LOC_W         = 2,
  parameter int PROG_CYCLES   = 8,
  parameter int ERASE_CYCLES  = 16,
  parameter int WINDOW_CYCLES = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [7:0]        wdata,
  input  logic              fault_inject,
  output logic [7:0]        rdata
);
  localparam int NSECT = 1 << SECT_W;

  logic              busy_prog, busy_erase, in_window, in_fault, fault_kind;
  logic              prog_fire, erase_fire;
  logic [NSECT-1:0]  erase_mask;
  logic [SECT_W-1:0] tgt_sect;
  logic [LOC_W-1:0]  tgt_loc;
  logic [7:0]        tgt_data;
  logic [7:0]        array_byte;
  logic              status_mode, prog_related, poll_bit, started_bit;

  fcs_decoder #(
    .ADDR_W(ADDR_W), .SECT_W(SECT_W), .LOC_W(LOC_W),
    .PROG_CYCLES(PROG_CYCLES), .ERASE_CYCLES(ERASE_CYCLES),
    .WINDOW_CYCLES(WINDOW_CYCLES)
  ) u_dec (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
    .fault_inject(fault_inject),
    .busy_prog(busy_prog), .busy_erase(busy_erase), .in_window(in_window),
    .in_fault(in_fault), .fault_kind(fault_kind),
    .prog_fire(prog_fire), .erase_fire(erase_fire), .erase_mask(erase_mask),
    .tgt_sect(tgt_sect), .tgt_loc(tgt_loc), .tgt_data(tgt_data)
  );

  fcs_array #(.SECT_W(SECT_W), .LOC_W(LOC_W)) u_arr (
    .clk(clk), .rst_n(rst_n),
    .prog_fire(prog_fire), .prog_sect(tgt_sect), .prog_loc(tgt_loc),
    .prog_data(tgt_data),
    .erase_fire(erase_fire), .erase_mask(erase_mask),
    .rd_sect(addr[ADDR_W-1 -: SECT_W]), .rd_loc(addr[LOC_W-1:0]),
    .rd_byte(array_byte)
  );

  assign status_mode  = busy_prog | busy_erase | in_window | in_fault;
  assign prog_related = busy_prog | (in_fault & ~fault_kind);
  assign poll_bit     = prog_related & ~tgt_data[7];
  assign started_bit  = busy_erase | (in_fault & fault_kind);

  fcs_readout u_rd (
    .clk(clk), .rst_n(rst_n), .rd_en(rd_en), .status_mode(status_mode),
    .poll_bit(poll_bit), .limit_bit(in_fault), .kind_bit(in_fault & fault_kind),
    .started_bit(started_bit), .array_byte(array_byte), .rdata(rdata)
  );

endmodule

// File: rtl/flash_cmd_seq_chk.sv
module flash_cmd_seq_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       wr_en,
  input logic       rd_en,
  input logic [7:0] wdata,
  input logic       fault_inject,
  input logic [7:0] rdata,
  input logic       busy_prog,
  input logic       busy_erase,
  input logic       in_window,
  input logic       in_fault,
  input logic       status_mode,
  input logic       prog_fire,
  input logic       erase_fire,
  input logic [7:0] array_byte
);

  assert_toggle_flip_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && status_mode) ##1 (rd_en && status_mode) |=> (rdata[6] != $past(rdata[6])));

  assert_fault_flag_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && in_fault) |=> rdata[5]);

  assert_fault_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (in_fault && !(wr_en && wdata == 8'hF0)) |=> in_fault);

  assert_erase_status_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && busy_erase) |=> (rdata[3] && !rdata[7] && !rdata[5]));

  assert_window_open_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && in_window) |=> (!rdata[3] && !rdata[7]));

  assert_prog_start_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy_prog) |-> $past(wr_en));

  assert_prog_holds_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_prog && !prog_fire && !fault_inject) |=> busy_prog);

  assert_erase_holds_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_erase && !erase_fire && !fault_inject) |=> busy_erase);

  assert_array_read_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && !status_mode) |=> (rdata == $past(array_byte)));

endmodule

bind flash_cmd_seq flash_cmd_seq_chk u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .wdata(wdata),
  .fault_inject(fault_inject), .rdata(rdata),
  .busy_prog(busy_prog), .busy_erase(busy_erase), .in_window(in_window),
  .in_fault(in_fault), .status_mode(status_mode),
  .prog_fire(prog_fire), .erase_fire(erase_fire), .array_byte(array_byte)
);

// File: tb/sim_flash_cmd_seq.sv
module sim_flash_cmd_seq;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic        rd_en = 1'b0;
  logic [16:0] addr = '0;
  logic [7:0]  wdata = '0;
  logic        fault_inject = 1'b0;
  logic [7:0]  rdata;

  int n_run = 0;
  int n_fail = 0;

  flash_cmd_seq u0 (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wdata(wdata), .fault_inject(fault_inject), .rdata(rdata)
  );

  always #10 clk = ~clk;

  // vector: kind(2) addr(17) data/expect(8) requirement(4)
  // kind 0 write, 1 read and compare, 2 idle for data cycles
  function automatic logic [30:0] tw(input logic [16:0] a, input logic [7:0] d);
    return {2'd0, a, d, 4'd0};
  endfunction
  function automatic logic [30:0] tr(input logic [16:0] a, input logic [7:0] e, input logic [3:0] r);
    return {2'd1, a, e, r};
  endfunction
  function automatic logic [30:0] tn(input logic [7:0] n);
    return {2'd2, 17'd0, n, 4'd0};
  endfunction

  localparam int NVEC = 55;
  localparam logic [30:0] VEC [NVEC] = '{
    tr(17'h00000, 8'hFF, 4'd1),                                   // R1 erased after reset
    tw(17'h05555, 8'hAA), tw(17'h02AAA, 8'h55), tw(17'h05555, 8'hA0),
    tw(17'h00001, 8'h12),
    tr(17'h00001, 8'h80, 4'd5),                                   // R5 poll = ~bit7
    tr(17'h00001, 8'hC0, 4'd6),                                   // R6 toggle flips
    tw(17'h00001, 8'h00),                                         // R5 ignored
    tn(8'd12),
    tr(17'h00001, 8'h12, 4'd4),                                   // R4 R12 programmed
    tw(17'h05555, 8'hAA), tw(17'h02AAA, 8'h55), tw(17'h05555, 8'hA0),
    tw(17'h00001, 8'hF1),
    tn(8'd12),
    tr(17'h00001, 8'h10, 4'd13),                                  // R13 AND merge
    tw(17'h1D555, 8'hAA), tw(17'h1AAAA, 8'h55), tw(17'h0D555, 8'hA0),
    tw(17'h0C002, 8'h34),
    tn(8'd12),
    tr(17'h0C002, 8'h34, 4'd2),                                   // R2 A16/A15 ignored
    tw(17'h05555, 8'hAA), tw(17'h02AAA, 8'h55), tw(17'h05555, 8'hA0),
    tw(17'h14003, 8'h56),
    tn(8'd12),
    tr(17'h14003, 8'h56, 4'd4),                                   // R4
    tw(17'h05555, 8'hAA), tw(17'h02AAA, 8'h66), tw(17'h05555, 8'hA0),
    tw(17'h0C002, 8'h00),
    tn(8'd12),
    tr(17'h0C002, 8'h34, 4'd2),                                   // R2 broken unlock
    tw(17'h05555, 8'hAA), tw(17'h02AAA, 8'h55), tw(17'h05555, 8'hF0),
    tw(17'h0C002, 8'h00),
    tn(8'd12),
    tr(17'h0C002, 8'h34, 4'd3),                                   // R3 reset command
    tw(17'h05555, 8'hAA), tw(17'h02AAA, 8'h55), tw(17'h05555, 8'h80),
    tw(17'h05555, 8'hAA), tw(17'h02AAA, 8'h55),
    tw(17'h00000, 8'h30),
    tr(17'h00000, 8'h00, 4'd8),                                   // R8 window open
    tr(17'h00000, 8'h40, 4'd8),
    tw(17'h0C001, 8'h30),
    tr(17'h00000, 8'h00, 4'd8),
    tr(17'h00000, 8'h40, 4'd8),
    tr(17'h00000, 8'h00, 4'd8),
    tr(17'h00000, 8'h40, 4'd8),                                   // R8 restart held
    tn(8'd2),
    tr(17'h00000, 8'h08, 4'd7)                                    // R7 erase started
  };

  task automatic summary();
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
  endtask

  task automatic check(input string tag, input logic [16:0] a,
                       input logic [7:0] got, input logic [7:0] exp);
    n_run++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s addr=%h got=%h exp=%h", tag, a, got, exp);
    end
  endtask

  task automatic op_write(input logic [16:0] a, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; rd_en = 1'b0; addr = a; wdata = d;
  endtask

  task automatic op_read(input logic [16:0] a, input logic [7:0] exp, input string tag);
    @(negedge clk);
    wr_en = 1'b0; rd_en = 1'b1; addr = a;
    @(posedge clk);
    #5;
    check(tag, a, rdata, exp);
  endtask

  task automatic op_idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      wr_en = 1'b0; rd_en = 1'b0;
    end
  endtask

  task automatic op_fault(input logic v);
    @(negedge clk);
    wr_en = 1'b0; rd_en = 1'b0; fault_inject = v;
  endtask

  task automatic unlock_pair();
    op_write(17'h05555, 8'hAA);
    op_write(17'h02AAA, 8'h55);
  endtask

  initial begin
    #(20 * 200000);
    n_fail++;
    $display("FAIL watchdog expired");
    summary();
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1 reset rdata", 17'h0, rdata, 8'h00);
    rst_n = 1'b1;

    for (int k = 0; k < NVEC; k++) begin
      logic [30:0] v;
      v = VEC[k];
      case (v[30:29])
        2'd0: op_write(v[28:12], v[11:4]);
        2'd1: op_read(v[28:12], v[11:4], $sformatf("R%0d vec%0d", v[3:0], k));
        default: op_idle(int'(v[11:4]));
      endcase
    end

    // erase in progress: an unlock write is dropped (R10)
    op_write(17'h05555, 8'hAA);
    op_idle(20);
    op_read(17'h00001, 8'hFF, "R8 sector0 erased");
    op_read(17'h0C002, 8'hFF, "R8 sector3 erased");
    op_read(17'h14003, 8'h56, "R8 sector5 kept");
    op_write(17'h02AAA, 8'h55);
    op_write(17'h05555, 8'hA0);
    op_write(17'h14003, 8'h00);
    op_idle(12);
    op_read(17'h14003, 8'h56, "R10 write during erase ignored");

    // window aborted by a foreign write (R9)
    unlock_pair(); op_write(17'h05555, 8'h80); unlock_pair();
    op_write(17'h14000, 8'h30);
    op_read(17'h14003, 8'h00, "R9 window status");
    op_write(17'h0C000, 8'hAA);
    op_read(17'h14003, 8'h56, "R9 back to read mode");
    op_idle(20);
    op_read(17'h14003, 8'h56, "R9 no erase after abort");

    // chip erase (R7, R12)
    unlock_pair(); op_write(17'h05555, 8'h80); unlock_pair();
    op_write(17'h05555, 8'h10);
    op_read(17'h00000, 8'h08, "R7 chip erase status");
    op_read(17'h00000, 8'h48, "R7 chip erase toggle");
    op_idle(20);
    op_read(17'h14003, 8'hFF, "R7 chip erased");
    op_read(17'h0C002, 8'hFF, "R12 read mode after erase");

    // program fault (R11)
    unlock_pair(); op_write(17'h05555, 8'hA0);
    op_write(17'h00001, 8'h12);
    op_fault(1'b1);
    op_read(17'h00001, 8'hA0, "R11 program fault status");
    op_read(17'h00001, 8'hE0, "R11 program fault toggle");
    op_fault(1'b0);
    op_idle(20);
    op_read(17'h00001, 8'hA0, "R11 fault sticky");
    op_write(17'h00000, 8'hF0);
    op_read(17'h00001, 8'hFF, "R11 program aborted");

    // erase fault (R11)
    unlock_pair(); op_write(17'h05555, 8'hA0);
    op_write(17'h00001, 8'h12);
    op_idle(12);
    unlock_pair(); op_write(17'h05555, 8'h80); unlock_pair();
    op_write(17'h05555, 8'h10);
    op_fault(1'b1);
    op_read(17'h00001, 8'h38, "R11 erase fault status");
    op_read(17'h00001, 8'h78, "R11 erase fault toggle");
    op_fault(1'b0);
    op_write(17'h00000, 8'hF0);
    op_read(17'h00001, 8'h12, "R11 erase aborted");

    // reset again (R1)
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    check("R1 rdata in reset", 17'h0, rdata, 8'h00);
    rst_n = 1'b1;
    op_read(17'h00001, 8'hFF, "R1 array after reset");
    op_idle(2);

    summary();
    $finish;
  end

endmodule